// File: doc/BRIEF.md
# Rotary Knob Step Decoder

This block turns one mechanical rotary encoder into clean step events. The encoder's two contacts idle high through pull-up resistors, so they present an inverted two-bit Gray code. The shaft pushbutton also pulls low when pressed. All three pins are asynchronous. Each one is resynchronized inside the block by a two-flop chain before any logic reads it.

A three-bit signed progress state follows the contact code. Clockwise motion counts it up and counter-clockwise motion counts it down. A step pulse is produced only when a full four-transition sequence lands back on the detent. Bounce, reversals and codes that skip a position are absorbed without producing a step. The button is filtered by a saturating up/down counter with hysteresis. The state machine and the button filter advance only on clocks where `sampleEn` is high, so the block can run from a slow tick such as an audio-rate strobe.

Top module: `knob_decoder`

## Requirements
- R1: After reset, `stepCw` and `stepCcw` are low and `btnPressed` is low (released).
- R2: Pin values are written {encA,encB}. The sequence 11, 10, 00, 01, 11 produces exactly one `stepCw` pulse, which appears when the code returns to 11 and not earlier.
- R3: The sequence 11, 01, 00, 10, 11 produces exactly one `stepCcw` pulse, which appears when the code returns to 11 and not earlier.
- R4: Every step pulse is high for exactly one clock.
- R5: A partial sequence that goes back to 11 produces no pulse. A code that steps backwards part-way through a sequence holds the progress state, and the sequence can then be resumed.
- R6: A code that is not the next one in either direction holds the progress state. This includes a jump in which both pins change at once, such as 11 to 00.
- R7: While `sampleEn` is low, pin activity does not advance the progress state and produces no step pulse.
- R8: With `btnN` low (pressed), `btnPressed` rises on the DEB_MAX-th consecutive sample, counted from a count of zero, and not before.
- R9: The press counter saturates at 0 and at DEB_MAX. `btnPressed` falls only when the counter reaches 0, and holds its value at every count in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | Evaluation tick for the state machine and the button filter |
| encA | input | 1 | Encoder contact A (code MSB), active low, asynchronous |
| encB | input | 1 | Encoder contact B (code LSB), active low, asynchronous |
| btnN | input | 1 | Shaft pushbutton, low when pressed, asynchronous |
| stepCw | output | 1 | One-clock pulse per completed clockwise detent |
| stepCcw | output | 1 | One-clock pulse per completed counter-clockwise detent |
| btnPressed | output | 1 | Debounced button level, high when pressed |

## Verification
The bench builds the block with DEB_MAX set to 5, so the saturation ceiling can be reached in a handful of samples. With that value the bench can hold the button past the ceiling and then count the exact number of releases that bring the output down. The synchronizer depth stays at its default of two. The button tests gate `sampleEn` so that each sample is counted exactly. This makes the off-by-one edges of the hysteresis band observable at the output pin.

// File: rtl/knob_pkg.sv
package knob_pkg;
  typedef logic [2:0] knobState_t;

  localparam knobState_t ST_HOME    = 3'b000;
  localparam knobState_t ST_CW_END  = 3'b011;
  localparam knobState_t ST_CCW_END = 3'b101;

  typedef struct packed {
    logic cwHit;
    logic ccwHit;
    logic cntUp;
    logic cntDn;
  } knobStrobe_t;
endpackage

// File: rtl/knob_sync.sv
module knob_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinSync
);
  logic [WIDTH-1:0] chain [STAGES];

  // Idle level of every pin is high (pull-up), so reset to ones
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '1;
          else       chain[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pinSync = chain[STAGES-1];
endmodule

// File: rtl/knob_ctrl.sv
module knob_ctrl
  import knob_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleEn,
  input  logic [1:0]  encSync,
  input  logic        btnSync,
  input  logic        cntAtMax,
  input  logic        cntAtZero,
  output knobStrobe_t strobe
);
  knobState_t stateQ, stateD;
  logic       invA, invB;
  logic [1:0] binPos;
  logic       pressed;

  // Active-low Gray code to binary position 0..3
  assign invA    = ~encSync[1];
  assign invB    = ~encSync[0];
  assign binPos  = {invA, invA ^ invB};
  assign pressed = ~btnSync;

  always_comb begin
    stateD        = stateQ;
    strobe.cwHit  = 1'b0;
    strobe.ccwHit = 1'b0;
    if (sampleEn) begin
      if (binPos == 2'd0) begin
        stateD        = ST_HOME;
        strobe.cwHit  = (stateQ == ST_CW_END);
        strobe.ccwHit = (stateQ == ST_CCW_END);
      end else if ({1'b0, binPos} == knobState_t'(stateQ + 3'd1)) begin
        stateD = stateQ + 3'd1;
      end else if ({1'b1, binPos} == knobState_t'(stateQ - 3'd1)) begin
        stateD = stateQ - 3'd1;
      end
    end
  end

  assign strobe.cntUp = sampleEn &  pressed & ~cntAtMax;
  assign strobe.cntDn = sampleEn & ~pressed & ~cntAtZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_HOME;
    else       stateQ <= stateD;
  end

  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(stateQ)); // R7
  AST_NO_MIN_STATE: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != 3'b100); // R6
  AST_HOME_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cwHit || strobe.ccwHit) |=> stateQ == ST_HOME); // R2
endmodule

// File: rtl/knob_datapath.sv
module knob_datapath
  import knob_pkg::*;
#(
  parameter int DEB_MAX = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  knobStrobe_t strobe,
  output logic        cntAtMax,
  output logic        cntAtZero,
  output logic        stepCw,
  output logic        stepCcw,
  output logic        btnLevel
);
  localparam int CNT_W = $clog2(DEB_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEB_MAX);

  logic [CNT_W-1:0] cntQ, cntD;
  logic             levelD;

  always_comb begin
    cntD = cntQ;
    if (strobe.cntUp)      cntD = cntQ + 1'b1;
    else if (strobe.cntDn) cntD = cntQ - 1'b1;
    if (cntD == CNT_TOP)   levelD = 1'b1;
    else if (cntD == '0)   levelD = 1'b0;
    else                   levelD = btnLevel;
  end

  assign cntAtMax  = (cntQ == CNT_TOP);
  assign cntAtZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      btnLevel <= 1'b0;
      stepCw   <= 1'b0;
      stepCcw  <= 1'b0;
    end else begin
      cntQ     <= cntD;
      btnLevel <= levelD;
      stepCw   <= strobe.cwHit;
      stepCcw  <= strobe.ccwHit;
    end
  end

  AST_CW_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    stepCw |=> !stepCw); // R4
  AST_CCW_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    stepCcw |=> !stepCcw); // R4
  AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(stepCw && stepCcw)); // R3
  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_TOP); // R9
  AST_RISE_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(btnLevel) |-> cntQ == CNT_TOP); // R8
  AST_FALL_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(btnLevel) |-> cntQ == '0); // R9
endmodule

// File: rtl/knob_decoder.sv
module knob_decoder
  import knob_pkg::*;
#(
  parameter int DEB_MAX     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleEn,
  input  logic encA,
  input  logic encB,
  input  logic btnN,
  output logic stepCw,
  output logic stepCcw,
  output logic btnPressed
);
  logic [2:0]  pinSync;
  knobStrobe_t strobe;
  logic        cntAtMax, cntAtZero;

  knob_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinIn({encA, encB, btnN}),
    .pinSync(pinSync)
  );

  knob_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn),
    .encSync(pinSync[2:1]), .btnSync(pinSync[0]),
    .cntAtMax(cntAtMax), .cntAtZero(cntAtZero),
    .strobe(strobe)
  );

  knob_datapath #(.DEB_MAX(DEB_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntAtMax(cntAtMax), .cntAtZero(cntAtZero),
    .stepCw(stepCw), .stepCcw(stepCcw), .btnLevel(btnPressed)
  );
endmodule

// File: tb/tb_knob_decoder.sv
module tb_knob_decoder;
  localparam int DEB = 5;
  localparam int NVEC = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0;
  logic encA = 1'b1, encB = 1'b1, btnN = 1'b1;
  logic stepCw, stepCcw, btnPressed;

  int checks = 0, fails = 0;
  int cwCount = 0, ccwCount = 0;
  int runCw = 0, runCcw = 0, maxRunCw = 0, maxRunCcw = 0;
  bit done = 1'b0;

  // {encA, encB, cumulative cw[3:0], cumulative ccw[3:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b10, 4'd0, 4'd0}, {2'b00, 4'd0, 4'd0}, {2'b01, 4'd0, 4'd0}, {2'b11, 4'd1, 4'd0},
    {2'b01, 4'd1, 4'd0}, {2'b00, 4'd1, 4'd0}, {2'b10, 4'd1, 4'd0}, {2'b11, 4'd1, 4'd1},
    {2'b10, 4'd1, 4'd1}, {2'b11, 4'd1, 4'd1}, {2'b00, 4'd1, 4'd1}, {2'b11, 4'd1, 4'd1},
    {2'b10, 4'd1, 4'd1}, {2'b00, 4'd1, 4'd1}, {2'b10, 4'd1, 4'd1}, {2'b00, 4'd1, 4'd1},
    {2'b01, 4'd1, 4'd1}, {2'b11, 4'd2, 4'd1}, {2'b01, 4'd2, 4'd1}, {2'b00, 4'd2, 4'd1},
    {2'b01, 4'd2, 4'd1}, {2'b00, 4'd2, 4'd1}, {2'b10, 4'd2, 4'd1}, {2'b11, 4'd2, 4'd2},
    {2'b01, 4'd2, 4'd2}, {2'b11, 4'd2, 4'd2}
  };

  knob_decoder #(.DEB_MAX(DEB)) dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn),
    .encA(encA), .encB(encB), .btnN(btnN),
    .stepCw(stepCw), .stepCcw(stepCcw), .btnPressed(btnPressed)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (stepCw) begin
      if (runCw == 0) cwCount++;
      runCw++;
      if (runCw > maxRunCw) maxRunCw = runCw;
    end else runCw = 0;
    if (stepCcw) begin
      if (runCcw == 0) ccwCount++;
      runCcw++;
      if (runCcw > maxRunCcw) maxRunCcw = runCcw;
    end else runCcw = 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic holdPins(input logic [1:0] p, input int cyc);
    @(negedge clk);
    {encA, encB} = p;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic setBtn(input logic v);
    @(negedge clk);
    sampleEn = 1'b0;
    btnN = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic sampleFor(input int k);
    sampleEn = 1'b1;
    repeat (k) @(negedge clk);
    sampleEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stepCw == 1'b0, "R1 stepCw after reset", stepCw, 0);
    check(stepCcw == 1'b0, "R1 stepCcw after reset", stepCcw, 0);
    check(btnPressed == 1'b0, "R1 btnPressed after reset", btnPressed, 0);

    // Table walk: R2 R3 R5 R6
    sampleEn = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      holdPins(VEC[i][9:8], 6);
      check(cwCount == int'(VEC[i][7:4]), $sformatf("R2 R5 R6 cw count at vector %0d", i),
            cwCount, int'(VEC[i][7:4]));
      check(ccwCount == int'(VEC[i][3:0]), $sformatf("R3 R5 R6 ccw count at vector %0d", i),
            ccwCount, int'(VEC[i][3:0]));
    end
    // R4 pulse width
    check(maxRunCw == 1, "R4 cw pulse width", maxRunCw, 1);
    check(maxRunCcw == 1, "R4 ccw pulse width", maxRunCcw, 1);

    // R7 full rotation with sampling disabled
    sampleEn = 1'b0;
    holdPins(2'b10, 6);
    holdPins(2'b00, 6);
    holdPins(2'b01, 6);
    holdPins(2'b11, 6);
    check(cwCount == 2, "R7 no cw step without sampleEn", cwCount, 2);
    sampleEn = 1'b1;
    repeat (6) @(negedge clk);
    check(cwCount == 2, "R7 no late cw step once sampling resumes", cwCount, 2);
    sampleEn = 1'b0;

    // Button filter: R8 R9
    setBtn(1'b0);
    sampleFor(DEB - 1);
    check(btnPressed == 1'b0, "R8 level low one sample short", btnPressed, 0);
    sampleFor(1);
    check(btnPressed == 1'b1, "R8 level high at ceiling", btnPressed, 1);
    setBtn(1'b1);
    sampleFor(3);
    check(btnPressed == 1'b1, "R9 level held inside band", btnPressed, 1);
    setBtn(1'b0);
    sampleFor(20);
    check(btnPressed == 1'b1, "R9 level high while saturated", btnPressed, 1);
    setBtn(1'b1);
    sampleFor(DEB - 1);
    check(btnPressed == 1'b1, "R9 ceiling saturation holds level", btnPressed, 1);
    sampleFor(1);
    check(btnPressed == 1'b0, "R9 level low at zero", btnPressed, 0);
    sampleFor(3);
    setBtn(1'b0);
    sampleFor(DEB - 1);
    check(btnPressed == 1'b0, "R9 floor saturation keeps level low", btnPressed, 0);
    sampleFor(1);
    check(btnPressed == 1'b1, "R8 level high again at ceiling", btnPressed, 1);

    done = 1'b1;
    finishRun();
  end
endmodule